// File: doc/BRIEF.md
# Line-Cycle Synchronized Energy Accumulator

This block integrates a stream of signed active-power samples over a programmed whole number of half-line cycles. Window boundaries are set by voltage zero-crossing strobes, so every window covers complete half cycles. Because the window is whole half cycles, the ripple at twice the line frequency cancels out of the sum. Each sample is first trimmed by a signed fractional gain and a signed offset. It is then added into a wide internal accumulator.

When the programmed number of half cycles has elapsed, the upper part of the accumulator is copied into a result register and a cycle-end flag is raised. The accumulator then clears, and the next window starts on the following clock with no dead time. An optional interrupt request follows the flag. The flag stays set until software clears it. Software that misses a window simply sees the result replaced by the newer one.

Top module: `lcyc_energy_acc`

## Requirements
- R1: While reset is high and on the cycle after it, `energy_o` is 0, `cyc_end_o` is 0 and `irq_o` is 0, and the block is disarmed.
- R2: Samples are ignored until the first `zc_i` pulse after reset. A valid sample presented in the same cycle as that arming pulse is the first sample of the first window. The arming pulse does not count as a completed half cycle.
- R3: Each accepted sample s contributes s + floor(s·g / 4096) + o, where g is `gain_i` read as a 12-bit two's-complement number and o is `ofs_i` read as a two's-complement number.
- R4: With N = `half_cyc_i` nonzero, a window ends in the cycle of the N-th `zc_i` pulse after the window began. A valid sample in that cycle belongs to the closing window.
- R5: At a window end, `energy_o` shows bits [ACC_W-1 : ACC_W-RES_W] of the accumulated sum from the next cycle on. The accumulator wraps modulo 2^ACC_W. The sum restarts from zero, and a sample in the very next cycle opens the new window.
- R6: `energy_o` changes only at a window end. It is overwritten at every window end whether or not it was read. Pulsing `rd_i` never changes it.
- R7: `cyc_end_o` is set in the cycle after a window end and holds until a `clr_i` pulse. A clear in the same cycle as a window end loses, and the flag stays set.
- R8: `irq_o` is high exactly when `cyc_end_o` and `irq_en_i` are both high, so it persists until the flag is cleared or the enable is dropped.
- R9: While `half_cyc_i` is 0, samples are not accumulated, zero crossings are not counted and no window ends. The partial sum and half-cycle count are kept. Counting resumes from them when N becomes nonzero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | SAMPLE_W | Signed active-power sample |
| smp_vld_i | input | 1 | Sample-valid strobe |
| zc_i | input | 1 | Voltage zero-crossing strobe, one per half cycle |
| gain_i | input | GAIN_W | Two's-complement fractional gain trim |
| ofs_i | input | OFS_W | Two's-complement offset added after gain |
| half_cyc_i | input | CNT_W | Window length in half cycles; 0 pauses |
| rd_i | input | 1 | Result read strobe (no side effect) |
| irq_en_i | input | 1 | Cycle-end interrupt enable |
| clr_i | input | 1 | Clears the cycle-end flag |
| energy_o | output | RES_W | Latched energy of the last completed window |
| cyc_end_o | output | 1 | Cycle-end status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the ones where a window edge coincides with something else. Two cases matter: a window closing on the same clock as a flag clear, and a window whose length is set to zero partway through and later restored. The bench drives both on chosen cycles. It compares the result against a cycle-by-cycle arithmetic model of the window rules. It also sweeps window lengths 1 to 4 against extreme and mid-range gains and several offsets. The zero-length pause is entered with a partial sum and count already built up, so the resumed window must finish from the held values.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;

    localparam int unsigned DEF_SAMPLE_W = 24;
    localparam int unsigned DEF_GAIN_W   = 12;
    localparam int unsigned DEF_OFS_W    = 16;
    localparam int unsigned DEF_ACC_W    = 48;
    localparam int unsigned DEF_RES_W    = 24;
    localparam int unsigned DEF_CNT_W    = 16;

    // Per-cycle window control decided by the half-cycle counter.
    typedef struct packed {
        logic add_en;   // add this cycle's corrected sample
        logic win_end;  // this cycle closes the window
    } win_ctl_t;

    // Width of a corrected sample: widest operand plus two growth bits.
    function automatic int unsigned corr_width(int unsigned sw, int unsigned ow);
        return ((sw > ow) ? sw : ow) + 2;
    endfunction

endpackage

// File: rtl/lcyc_scaler.sv
module lcyc_scaler #(
    parameter int unsigned SW = 24,
    parameter int unsigned GW = 12,
    parameter int unsigned OW = 16,
    parameter int unsigned CW = 26
) (
    input  logic [SW-1:0]        smp_i,
    input  logic [GW-1:0]        gain_i,
    input  logic [OW-1:0]        ofs_i,
    output logic signed [CW-1:0] corr_o
);
    localparam int unsigned PW = SW + GW;

    logic signed [SW-1:0] smp_s;
    logic signed [GW-1:0] gain_s;
    logic signed [OW-1:0] ofs_s;
    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] trim;
    logic [GW-1:0]        frac_unused;

    assign smp_s  = signed'(smp_i);
    assign gain_s = signed'(gain_i);
    assign ofs_s  = signed'(ofs_i);

    // s * g, then drop GW fraction bits (arithmetic floor)
    assign prod        = PW'(smp_s) * PW'(gain_s);
    assign trim        = signed'(prod[PW-1:GW]);
    assign frac_unused = prod[GW-1:0];

    assign corr_o = CW'(smp_s) + CW'(trim) + CW'(ofs_s);

endmodule

// File: rtl/lcyc_window.sv
module lcyc_window
    import lcyc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic             zc_i,
    input  logic [CNT_W-1:0] half_cyc_i,
    output win_ctl_t         ctl_o,
    output logic             armed_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             run;
    logic [CNT_W:0]   cnt_inc;
    logic             hit;
    logic             step;

    assign run     = |half_cyc_i;
    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign hit     = cnt_inc >= {1'b0, half_cyc_i};
    assign step    = armed_q & zc_i & run;

    always_comb begin
        ctl_o.win_end = step & hit;
        ctl_o.add_en  = vld_i & (armed_q | zc_i) & run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (zc_i) begin
                armed_q <= 1'b1;
            end
            if (step & hit) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/lcyc_integrator.sv
module lcyc_integrator
    import lcyc_pkg::*;
#(
    parameter int unsigned AW = 48,
    parameter int unsigned RW = 24,
    parameter int unsigned CW = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  win_ctl_t             ctl_i,
    input  logic signed [CW-1:0] corr_i,
    output logic [RW-1:0]        res_o
);
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_sum;
    logic [RW-1:0] res_q;

    assign acc_sum = acc_q + (ctl_i.add_en ? AW'(corr_i) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (ctl_i.win_end) begin
            res_q <= acc_sum[AW-1 -: RW];
            acc_q <= '0;
        end else begin
            acc_q <= acc_sum;
        end
    end

    assign res_o = res_q;

endmodule

// File: rtl/lcyc_status.sv
module lcyc_status (
    input  logic clk,
    input  logic rst,
    input  logic win_end_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (win_end_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

endmodule

// File: rtl/lcyc_energy_acc.sv
module lcyc_energy_acc
    import lcyc_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned GAIN_W   = DEF_GAIN_W,
    parameter int unsigned OFS_W    = DEF_OFS_W,
    parameter int unsigned ACC_W    = DEF_ACC_W,
    parameter int unsigned RES_W    = DEF_RES_W,
    parameter int unsigned CNT_W    = DEF_CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                smp_vld_i,
    input  logic                zc_i,
    input  logic [GAIN_W-1:0]   gain_i,
    input  logic [OFS_W-1:0]    ofs_i,
    input  logic [CNT_W-1:0]    half_cyc_i,
    input  logic                rd_i,
    input  logic                irq_en_i,
    input  logic                clr_i,
    output logic [RES_W-1:0]    energy_o,
    output logic                cyc_end_o,
    output logic                irq_o
);
    localparam int unsigned CORR_W = corr_width(SAMPLE_W, OFS_W);

    win_ctl_t                 ctl;
    logic                     armed;
    logic                     win_end;
    logic signed [CORR_W-1:0] corr;
    logic                     rd_unused;

    // The result register has no read side effect.
    assign rd_unused = rd_i;
    assign win_end   = ctl.win_end;

    lcyc_scaler #(
        .SW(SAMPLE_W), .GW(GAIN_W), .OW(OFS_W), .CW(CORR_W)
    ) u_scale (
        .smp_i  (smp_i),
        .gain_i (gain_i),
        .ofs_i  (ofs_i),
        .corr_o (corr)
    );

    lcyc_window #(
        .CNT_W(CNT_W)
    ) u_win (
        .clk        (clk),
        .rst        (rst),
        .vld_i      (smp_vld_i),
        .zc_i       (zc_i),
        .half_cyc_i (half_cyc_i),
        .ctl_o      (ctl),
        .armed_o    (armed)
    );

    lcyc_integrator #(
        .AW(ACC_W), .RW(RES_W), .CW(CORR_W)
    ) u_int (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .corr_i (corr),
        .res_o  (energy_o)
    );

    lcyc_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .win_end_i (win_end),
        .clr_i     (clr_i),
        .irq_en_i  (irq_en_i),
        .flag_o    (cyc_end_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/lcyc_checker.sv
module lcyc_checker #(
    parameter int unsigned RW = 24,
    parameter int unsigned NW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          zc_i,
    input logic          rd_i,
    input logic          clr_i,
    input logic          irq_en_i,
    input logic [NW-1:0] half_cyc_i,
    input logic [RW-1:0] energy_o,
    input logic          cyc_end_o,
    input logic          irq_o,
    input logic          win_end,
    input logic          armed
);
    AST_NO_END_BEFORE_ARM: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !win_end);                                            // R2

    AST_END_NEEDS_ZC: assert property (@(posedge clk) disable iff (rst)
        win_end |-> zc_i);                                               // R4

    AST_RESULT_MOVES_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(energy_o) |-> $past(win_end));                          // R6

    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !win_end) |=> $stable(energy_o));                       // R6

    AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (rst)
        win_end |=> cyc_end_o);                                          // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc_end_o && !clr_i) |=> cyc_end_o);                            // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clr_i && irq_en_i) |=> (irq_o || !irq_en_i));         // R8

    AST_ZERO_LEN_NO_END: assert property (@(posedge clk) disable iff (rst)
        (half_cyc_i == '0) |-> !win_end);                                // R9

endmodule

bind lcyc_energy_acc lcyc_checker #(
    .RW(RES_W), .NW(CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .zc_i       (zc_i),
    .rd_i       (rd_i),
    .clr_i      (clr_i),
    .irq_en_i   (irq_en_i),
    .half_cyc_i (half_cyc_i),
    .energy_o   (energy_o),
    .cyc_end_o  (cyc_end_o),
    .irq_o      (irq_o),
    .win_end    (win_end),
    .armed      (armed)
);

// File: tb/sim_lcyc_energy_acc.sv
module sim_lcyc_energy_acc;
    localparam int SW = 16;
    localparam int AW = 32;
    localparam int RW = 16;
    localparam time CYC = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] smp_i = '0;
    logic          smp_vld_i = 1'b0;
    logic          zc_i = 1'b0;
    logic [11:0]   gain_i = '0;
    logic [15:0]   ofs_i = '0;
    logic [15:0]   half_cyc_i = '0;
    logic          rd_i = 1'b0;
    logic          irq_en_i = 1'b0;
    logic          clr_i = 1'b0;
    logic [RW-1:0] energy_o;
    logic          cyc_end_o;
    logic          irq_o;

    always #(CYC/2) clk = ~clk;

    lcyc_energy_acc #(
        .SAMPLE_W(SW), .GAIN_W(12), .OFS_W(16),
        .ACC_W(AW), .RES_W(RW), .CNT_W(16)
    ) u0 (.*);

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    // bench model state
    longint      acc_m = 0;
    longint      res_m = 0;
    bit          armed_m = 0;
    bit          flag_m = 0;
    int          cnt_m = 0;
    logic [11:0] gain_t = '0;
    logic [15:0] ofs_t = '0;
    int          n_t = 0;
    bit          en_t = 0;
    int unsigned lcg = 32'h1234_5678;

    localparam longint ACC_MASK = (64'd1 << AW) - 1;
    localparam longint RES_MASK = (64'd1 << RW) - 1;

    task automatic check(string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("energy", longint'(energy_o), res_m);
        check("flag R7", longint'(cyc_end_o), longint'(flag_m));
        check("irq R8", longint'(irq_o), longint'(flag_m & en_t));
    endtask

    // one clock: drive at negedge, update model, sample after the edge
    task automatic step(logic [SW-1:0] s, bit v, bit z, bit r, bit c);
        longint sl, gl, ol, corr, accn;
        bit run, add, fin;
        @(negedge clk);
        smp_i = s; smp_vld_i = v; zc_i = z; rd_i = r; clr_i = c;
        gain_i = gain_t; ofs_i = ofs_t; half_cyc_i = 16'(n_t); irq_en_i = en_t;
        sl = longint'($signed(s));
        gl = longint'($signed(gain_t));
        ol = longint'($signed(ofs_t));
        corr = sl + ((sl * gl) >>> 12) + ol;
        run = (n_t != 0);
        add = v && (armed_m || z) && run;
        fin = armed_m && z && run && (cnt_m + 1 >= n_t);
        accn = (acc_m + (add ? corr : 0)) & ACC_MASK;
        if (fin) begin
            res_m = (accn >> (AW - RW)) & RES_MASK;
            acc_m = 0;
            cnt_m = 0;
        end else begin
            acc_m = accn;
            if (armed_m && z && run) cnt_m++;
        end
        if (z) armed_m = 1;
        if (fin) flag_m = 1;
        else if (c) flag_m = 0;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    function automatic logic [SW-1:0] next_sample();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        if (lcg[7:4] == 4'd0) return SW'(-$signed({1'b0, lcg[29:15]}));
        return {1'b0, lcg[30:16]};
    endfunction

    task automatic half_cycle(int len, bit gaps);
        for (int k = 0; k < len - 1; k++) begin
            logic [SW-1:0] s;
            s = next_sample();
            step(s, gaps ? (lcg[2:1] != 2'b00) : 1'b1, 1'b0, 1'b0, 1'b0);
        end
        step(next_sample(), 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        logic [11:0] gains[4];
        logic [15:0] offs[3];
        gains = '{12'h000, 12'h7FF, 12'h800, 12'h3E8};
        offs  = '{16'h0000, 16'hFED4, 16'h04D2};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        compare_all();
        rst = 1'b0;
        n_t = 2;
        step('0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R2: samples before the first zero crossing are ignored
        tag = "R2";
        for (int k = 0; k < 30; k++) step(16'h7000, 1'b1, 1'b0, 1'b0, 1'b0);
        step(16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0);   // arming crossing, sample counts
        half_cycle(40, 1'b0);
        half_cycle(40, 1'b0);                      // first window closes here
        check("R2 window closed after two half cycles", longint'(cyc_end_o), 1);

        // R3 R4 R5: sweep of window length, gain and offset
        tag = "R3 R4 R5 sweep";
        for (int n = 1; n <= 4; n++) begin
            for (int gi = 0; gi < 4; gi++) begin
                for (int oi = 0; oi < 3; oi++) begin
                    n_t = n; gain_t = gains[gi]; ofs_t = offs[oi];
                    for (int w = 0; w < n + 1; w++) half_cycle(40, w[0]);
                end
            end
        end

        // R6: reads do nothing, unread result is overwritten
        tag = "R6";
        n_t = 1; gain_t = '0; ofs_t = '0;
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 30; k++) step(16'h7FFF, 1'b1, 1'b0, k[2], 1'b0);
            step(16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0);
            ofs_t = 16'(w * 1000);
        end

        // R7 R8: clear, enable, and clear colliding with window end
        tag = "R7";
        en_t = 1;
        step('0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 cleared", longint'(cyc_end_o), 0);
        half_cycle(20, 1'b0);
        tag = "R8";
        check("R8 irq raised", longint'(irq_o), 1);
        for (int k = 0; k < 10; k++) step('0, 1'b0, 1'b0, 1'b0, 1'b0);
        en_t = 0;
        step('0, 1'b0, 1'b0, 1'b0, 1'b0);
        en_t = 1;
        step('0, 1'b0, 1'b0, 1'b0, 1'b1);
        tag = "R7 collision";
        for (int k = 0; k < 10; k++) step(16'h6000, 1'b1, 1'b0, 1'b0, 1'b0);
        step(16'h6000, 1'b1, 1'b1, 1'b0, 1'b1);     // end and clear together
        check("R7 set wins over clear", longint'(cyc_end_o), 1);

        // R9: zero length pauses, then resumes from held state
        tag = "R9";
        n_t = 3; en_t = 0;
        half_cycle(40, 1'b0);
        n_t = 0;
        for (int w = 0; w < 5; w++) half_cycle(25, 1'b0);
        check("R9 no end while paused", longint'(cyc_end_o), 1);
        step('0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int w = 0; w < 3; w++) half_cycle(25, 1'b0);
        check("R9 still no end", longint'(cyc_end_o), 0);
        n_t = 3;
        half_cycle(40, 1'b0);
        half_cycle(40, 1'b0);
        check("R9 resumed window ended", longint'(cyc_end_o), 1);
        for (int w = 0; w < 6; w++) half_cycle(40, 1'b1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CYC * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule